// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a pixel clock into the timing signals of a raster display: horizontal sync, vertical sync, a data-enable strobe, the column and row of the current pixel, and a pixel data bus passed through with a selectable inversion. It also raises an interrupt when vertical sync begins. A simple write port reaches every setting. Each axis has four segment lengths. There is also a polarity word, a run/stop command, an interrupt mask and a write-one-to-clear raw status bit.

Software stops the generator and programs the segment lengths and polarities. It then writes the run command. Counting begins at the first visible pixel of the top line. Timing and polarity written while the generator runs are held back until the current frame ends, so a frame is never split between two timings. The command, the mask and the status clear act at once.

Top module: `vtg_top`

## Requirements
- R1: The four horizontal length registers (address 0 visible, 1 front porch, 2 sync, 3 back porch) each hold a pixel-clock count minus one, and a line lasts the sum of the four counts.
- R2: The four vertical length registers (address 4 visible, 5 front porch, 6 sync, 7 back porch) each hold a line count minus one, and a frame lasts the sum of the four counts in lines.
- R3: On each axis the segments run visible, front porch, sync, back porch. Sync begins on the count right after visible plus front porch. Data enable is active only where both axes are in their visible segment.
- R4: The polarity register (address 8) uses bit 0 for hsync, bit 1 for vsync and bit 2 for data enable. A set bit drives that output high when active and low when idle, and a clear bit inverts it. The reset value is all ones.
- R5: Writing bit 0 of the command register (address 9) as 1 starts the generator and writing 0 stops it. While stopped, the coordinates read zero and every output sits at its idle level after polarity. After a start, the first output cycle is column 0 of row 0.
- R6: Bit 0 of the mask register (address 10) gates the raw status onto the interrupt output. A mask change acts from the next cycle.
- R7: The raw status is set with the first pixel clock of the vertical sync segment and stays set until a write of 1 to bit 0 of address 11.
- R8: Polarity bit 3 controls the data bus. When set, visible pixels pass unchanged and blanking drives all zeros. When clear, visible pixels are inverted and blanking drives all ones.
- R9: Length and polarity writes made while running take effect only from the first pixel of the next frame. While stopped, they take effect at once.
- R10: The coordinate outputs give the column and row of the pixel shown. The row advances by one only when a line completes, and both wrap to zero at the end of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| pixel_in | input | DW | Pixel data for the current position |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pixel_out | output | DW | Pixel data after polarity and blanking |
| pix_x | output | CW | Current column |
| pix_y | output | CW | Current row |
| irq | output | 1 | Masked vertical-sync interrupt |
| irq_raw | output | 1 | Raw vertical-sync status |

## Verification
A wrong counter bound shows up within one line as a data-enable or hsync edge at the wrong column. A wrong line-advance condition shows up at the first line boundary as a row number out of step with the column wrapping to zero. A status flag set on the wrong row, or one that fails to hold, shows at the raw interrupt pin on the sync line itself. A frame-boundary load that fires too early shows as a changed segment length in the frame that was already running, within the rest of that frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [3:0] {
    A_H_ACT  = 4'd0,
    A_H_FP   = 4'd1,
    A_H_SYNC = 4'd2,
    A_H_BP   = 4'd3,
    A_V_ACT  = 4'd4,
    A_V_FP   = 4'd5,
    A_V_SYNC = 4'd6,
    A_V_BP   = 4'd7,
    A_POL    = 4'd8,
    A_CMD    = 4'd9,
    A_IMASK  = 4'd10,
    A_ISTAT  = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic data;
    logic de;
    logic vs;
    logic hs;
  } pol_t;

  localparam int SEGS = 4;

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [3:0]              wr_addr,
  input  logic [CW-1:0]           wr_data,
  input  logic                    frame_load,
  input  logic                    stat_set,
  output logic [SEGS-1:0][CW-1:0] h_len,
  output logic [SEGS-1:0][CW-1:0] v_len,
  output pol_t                    pol,
  output logic                    run,
  output logic                    imask,
  output logic                    stat
);

  logic [SEGS-1:0][CW-1:0] h_sh, v_sh;
  pol_t                    pol_sh;
  logic                    clr_hit;

  assign clr_hit = wr_en && (wr_addr == A_ISTAT) && wr_data[0];

  // shadow copies, written by software at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      h_sh   <= '0;
      v_sh   <= '0;
      pol_sh <= 4'hF;
      run    <= 1'b0;
      imask  <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr[3:2] == 2'b00) h_sh[wr_addr[1:0]] <= wr_data;
      if (wr_addr[3:2] == 2'b01) v_sh[wr_addr[1:0]] <= wr_data;
      if (wr_addr == A_POL)   pol_sh <= wr_data[3:0];
      if (wr_addr == A_CMD)   run    <= wr_data[0];
      if (wr_addr == A_IMASK) imask  <= wr_data[0];
    end
  end

  // working copies, refreshed only at a frame boundary or while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      h_len <= '0;
      v_len <= '0;
      pol   <= 4'hF;
    end else if (frame_load) begin
      h_len <= h_sh;
      v_len <= v_sh;
      pol   <= pol_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           stat <= 1'b0;
    else if (stat_set) stat <= 1'b1;
    else if (clr_hit)  stat <= 1'b0;
  end

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    hold,
  input  logic [SEGS-1:0][CW-1:0] len,
  output logic [CW-1:0]           cnt,
  output logic                    last,
  output logic                    in_act,
  output logic                    in_sync,
  output logic                    first,
  output logic                    sync_first
);

  localparam int SW = CW + 2;

  logic [SW-1:0] e_act, e_slo, e_shi, e_last, c;

  assign c = SW'(cnt);

  always_comb begin
    e_act  = SW'(len[0]) + SW'(1);
    e_slo  = SW'(len[0]) + SW'(len[1]) + SW'(2);
    e_shi  = e_slo + SW'(len[2]) + SW'(1);
    e_last = e_shi + SW'(len[3]);
  end

  assign last       = (c == e_last);
  assign in_act     = (c < e_act);
  assign in_sync    = (c >= e_slo) && (c < e_shi);
  assign first      = (cnt == '0);
  assign sync_first = (c == e_slo);

  always_ff @(posedge clk) begin
    if (rst || hold) cnt <= '0;
    else if (adv)    cnt <= last ? '0 : cnt + CW'(1);
  end

endmodule

// File: rtl/vtg_out.sv
module vtg_out
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [1:0]    act,
  input  logic [1:0]    sync,
  input  logic [CW-1:0] hc,
  input  logic [CW-1:0] vc,
  input  pol_t          pol,
  input  logic [DW-1:0] pixel_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [DW-1:0] pixel_out,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y
);

  logic          de_raw, hs_raw, vs_raw;
  logic [DW-1:0] pix_d;

  assign de_raw = run & act[0] & act[1];
  assign hs_raw = run & sync[0];
  assign vs_raw = run & sync[1];

  always_comb begin
    if (de_raw) pix_d = pol.data ? pixel_in : ~pixel_in;
    else        pix_d = pol.data ? '0 : '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      de        <= 1'b0;
      pixel_out <= '0;
      pix_x     <= '0;
      pix_y     <= '0;
    end else begin
      hsync     <= ~(hs_raw ^ pol.hs);
      vsync     <= ~(vs_raw ^ pol.vs);
      de        <= ~(de_raw ^ pol.de);
      pixel_out <= pix_d;
      pix_x     <= run ? hc : '0;
      pix_y     <= run ? vc : '0;
    end
  end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [DW-1:0] pixel_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [DW-1:0] pixel_out,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          irq,
  output logic          irq_raw
);

  localparam int AXES = 2;

  logic [SEGS-1:0][CW-1:0] h_len, v_len;
  logic [SEGS-1:0][CW-1:0] ax_len [AXES];
  logic [CW-1:0]           ax_cnt [AXES];
  logic [AXES-1:0]         ax_adv, ax_last, ax_act, ax_sync, ax_first, ax_sfirst;
  pol_t                    pol;
  logic                    run, imask, frame_load, stat_set;

  assign ax_len[0]  = h_len;
  assign ax_len[1]  = v_len;
  assign ax_adv[0]  = run;
  assign ax_adv[1]  = run & ax_last[0];
  assign frame_load = ~run | (ax_last[0] & ax_last[1]);
  assign stat_set   = run & ax_first[0] & ax_sfirst[1];

  vtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_load(frame_load), .stat_set(stat_set),
    .h_len(h_len), .v_len(v_len), .pol(pol), .run(run), .imask(imask), .stat(irq_raw)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    vtg_axis #(.CW(CW)) u_axis (
      .clk(clk), .rst(rst), .adv(ax_adv[a]), .hold(~run), .len(ax_len[a]),
      .cnt(ax_cnt[a]), .last(ax_last[a]), .in_act(ax_act[a]), .in_sync(ax_sync[a]),
      .first(ax_first[a]), .sync_first(ax_sfirst[a])
    );
  end

  vtg_out #(.CW(CW), .DW(DW)) u_out (
    .clk(clk), .rst(rst), .run(run), .act(ax_act), .sync(ax_sync),
    .hc(ax_cnt[0]), .vc(ax_cnt[1]), .pol(pol), .pixel_in(pixel_in),
    .hsync(hsync), .vsync(vsync), .de(de), .pixel_out(pixel_out),
    .pix_x(pix_x), .pix_y(pix_y)
  );

  assign irq = irq_raw & imask;

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_en,
  input logic [3:0]              wr_addr,
  input logic [CW-1:0]           wr_data,
  input logic                    run,
  input logic                    frame_load,
  input logic [SEGS-1:0][CW-1:0] h_len,
  input pol_t                    pol,
  input logic                    hsync,
  input logic                    vsync,
  input logic                    de,
  input logic [CW-1:0]           pix_x,
  input logic [CW-1:0]           pix_y,
  input logic                    irq_raw
);

  p_idle_xy_r5: assert property (@(posedge clk) disable iff (rst)
    (!run && $past(!run)) |-> (pix_x == '0 && pix_y == '0));

  p_stat_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_raw && !(wr_en && wr_addr == A_ISTAT && wr_data[0])) |=> irq_raw);

  p_stat_in_vs_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_raw) |-> (vsync == $past(pol.vs)));

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(frame_load)) |-> $stable(h_len));

  p_row_step_r10: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && pix_y != $past(pix_y)) |-> pix_x == '0);

  p_de_hs_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (de == $past(pol.de)) |-> (hsync != $past(pol.hs)));

endmodule

bind vtg_top vtg_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run(run), .frame_load(frame_load), .h_len(h_len), .pol(pol),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
  .irq_raw(irq_raw)
);

// File: tb/vtg_top_test.sv
module vtg_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int DW = 8;
  localparam int NV = 14;
  // {k[7:0], 5'b0, de, hs, vs}; k = row*10 + column, timing H 4/2/3/1, V 3/1/2/2
  localparam logic [15:0] VEC [NV] = '{
    16'h0004, 16'h0304, 16'h0400, 16'h0602, 16'h0802, 16'h0900, 16'h0A04,
    16'h1404, 16'h1E00, 16'h2402, 16'h2801, 16'h3803, 16'h3C00, 16'h4F00
  };

  logic clk = 0, rst = 1, wr_en = 0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [DW-1:0] pixel_in = 8'hA5;
  logic hsync, vsync, de, irq, irq_raw;
  logic [DW-1:0] pixel_out;
  logic [CW-1:0] pix_x, pix_y;
  int total = 0, bad = 0;

  vtg_top #(.CW(CW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pixel_in(pixel_in), .hsync(hsync), .vsync(vsync), .de(de), .pixel_out(pixel_out),
    .pix_x(pix_x), .pix_y(pix_y), .irq(irq), .irq_raw(irq_raw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R4 reset outputs", {hsync, vsync, de, irq, irq_raw}, 5'b0);

    wr(0, 3); wr(1, 1); wr(2, 2); wr(3, 0);
    wr(4, 2); wr(5, 0); wr(6, 1); wr(7, 1);
    wr(9, 1);
    // table walk: R1 R2 R3 R10
    idx = 0;
    for (int k = 0; k <= 80; k++) begin
      @(negedge clk);
      if (idx < NV && int'(VEC[idx][15:8]) == k) begin
        chk(k < 30 ? "R1 R3 segments" : "R2 R3 segments", {de, hsync, vsync}, VEC[idx][2:0]);
        chk("R10 coords", {pix_y, pix_x}, {CW'(k / 10), CW'(k % 10)});
        idx++;
      end
      if (k == 0)  chk("R8 visible data", pixel_out, 8'hA5);
      if (k == 4)  chk("R8 blank data", pixel_out, 8'h00);
      if (k == 39) chk("R7 status before sync", irq_raw, 0);
      if (k == 40) chk("R7 status at sync start", irq_raw, 1);
      if (k == 40) chk("R6 masked irq", irq, 0);
      if (k == 80) chk("R2 frame wrap", {de, pix_y, pix_x}, {1'b1, CW'(0), CW'(0)});
    end
    wr(10, 1);
    chk("R6 unmasked irq", irq, 1);
    wr(11, 1);
    chk("R7 status cleared", {irq_raw, irq}, 2'b00);

    wr(9, 0);
    @(negedge clk);
    chk("R5 stopped idle", {de, hsync, vsync, pix_x, pix_y}, '0);
    wr(8, 0);
    @(negedge clk); @(negedge clk);
    chk("R4 inverted idle levels", {de, hsync, vsync}, 3'b111);
    chk("R8 inverted blank", pixel_out, 8'hFF);
    wr(9, 1);
    @(negedge clk);
    chk("R5 restart first pixel", {de, hsync, pix_x, pix_y}, {2'b01, CW'(0), CW'(0)});
    chk("R8 inverted data", pixel_out, 8'h5A);

    wr(9, 0);
    wr(8, 4'hF);
    wr(9, 1);
    // mid-frame length write: R9
    for (int k = 0; k <= 86; k++) begin
      @(negedge clk);
      if (k == 10) begin wr_en = 1; wr_addr = 0; wr_data = 5; end
      if (k == 11) wr_en = 0;
      if (k == 24) chk("R9 old timing kept", de, 0);
      if (k == 80) chk("R9 old frame length", {pix_y, pix_x}, {CW'(0), CW'(0)});
      if (k == 85) chk("R1 new visible length", de, 1);
      if (k == 86) chk("R1 new front porch", de, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule